// File: doc/BRIEF.md
# Write-Start Guard for a Parallel Non-Volatile Memory

This block sits between the raw control pins of a byte-wide non-volatile memory and its internal program sequencer, and decides when a write cycle may begin. A write is requested when chip enable and write enable are both low while output enable is high. Whichever of the two enables falls last begins the request. The guard passes on a single-cycle start pulse only when four independent conditions allow it. The request must outlast a minimum width, so short noise spikes are rejected. The supply must be good. A power-on settling delay must have elapsed since the supply last became good. The control pins must describe a write and not a read or an idle bus.

All four inputs are brought into the clock domain through a parameterised synchroniser chain. The minimum strobe width and the hold-off delay are both counted in clock cycles. A status output reports when writes are locked out by the supply: either the supply is low or the hold-off is still running. The analog supply comparator lives outside the block and appears here only as a digital flag.

Top module: `nvm_write_guard`

## Requirements
- R1: A write request means ce_n = 0, we_n = 0 and oe_n = 1 at the same sample. Suppose the pins first show a request before clock edge E0 and stay that way through edge E(FILT_CYCLES-1). Then wr_start_o is high during the cycle after edge E(FILT_CYCLES+SYNC_STAGES-1). A request held for fewer than FILT_CYCLES edges produces no pulse.
- R2: One accepted request produces exactly one wr_start_o pulse, one clock wide, however long the request lasts.
- R3: No pulse is produced while oe_n is 0, while ce_n is 1, or while we_n is 1. The request count starts only when the last of the two enables falls.
- R4: While rst is high, and in the cycle after it, wr_start_o is 0 and wr_inhibit_o is 1.
- R5: Suppose vdd_ok rises before edge E0 and then stays high. wr_inhibit_o stays 1 through edge E(HOLD_CYCLES+SYNC_STAGES-2) and is 0 after edge E(HOLD_CYCLES+SYNC_STAGES-1).
- R6: Suppose vdd_ok falls before edge E0. wr_inhibit_o is 1 after edge E(SYNC_STAGES), and no pulse is produced while the sampled flag is low. Every drop of the flag, even a one-cycle dip, restarts the full hold-off, measured from its next rise.
- R7: A request that completes its minimum width while writes are locked out is discarded. It gives no pulse later, even if the lockout ends while the request is still held.
- R8: A request that returns to idle for a single sampled cycle and then reasserts for the full width counts as a second write and gives a second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Raw chip enable, active low |
| we_n | input | 1 | Raw write enable, active low |
| oe_n | input | 1 | Raw output enable, active low |
| vdd_ok | input | 1 | Supply-above-threshold flag from the comparator |
| wr_start_o | output | 1 | Single-cycle qualified write-start pulse |
| wr_inhibit_o | output | 1 | High while the supply is low or the hold-off runs |

## Verification
The bench builds the guard with FILT_CYCLES = 5, HOLD_CYCLES = 40 and SYNC_STAGES = 2. A 5-cycle minimum at the 4 ns bench clock equals the 20 ns glitch limit. The 40-cycle hold-off replaces a millisecond delay, so a full settling period, its restart after a supply dip, and a request held across its end all fit in a short run. With two synchroniser stages, every latency the requirements state is checked with the pipeline offset included. Pulses of exactly the minimum width and one cycle short of it can be compared side by side.

// File: rtl/wg_pkg.sv
package wg_pkg;

  // Sampled view of the three active-low control pins.
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } wg_ctrl_t;

  // A write is described only by both enables low with the output driver off.
  function automatic logic wg_is_write(wg_ctrl_t c);
    return (!c.ce_n) && (!c.we_n) && c.oe_n;
  endfunction

endpackage

// File: rtl/wg_sync.sv
module wg_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/wg_strobe_filter.sv
module wg_strobe_filter #(
  parameter int FILT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic accept
);

  localparam int             CW   = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0]  LIM  = CW'(FILT_CYCLES);
  localparam logic [CW-1:0]  LAST = CW'(FILT_CYCLES - 1);

  // Saturating run-length counter: once it reaches LIM the request is spent
  // until req drops, which gives the one-pulse-per-strobe rule for free.
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)               run_cnt <= '0;
    else if (!req)         run_cnt <= '0;
    else if (run_cnt != LIM) run_cnt <= run_cnt + 1'b1;
  end

  assign accept = req && (run_cnt == LAST);

  assert_single_accept_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);

  assert_run_bounded_R1: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= LIM);

  assert_idle_clears_R8: assert property (@(posedge clk) disable iff (rst)
    !req |=> (run_cnt == '0));

endmodule

// File: rtl/wg_holdoff.sv
module wg_holdoff #(
  parameter int HOLD_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  output logic ready_o,
  output logic inhibit_o
);

  localparam int            CW   = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] hcnt;
  logic          ready_q;
  logic          inhibit_q;
  logic          ready_d;

  assign ready_d = supply_ok && (ready_q || (hcnt == LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt      <= '0;
      ready_q   <= 1'b0;
      inhibit_q <= 1'b1;
    end else begin
      ready_q   <= ready_d;
      inhibit_q <= !ready_d;
      if (!supply_ok)                    hcnt <= '0;
      else if (!ready_q && hcnt != LAST) hcnt <= hcnt + 1'b1;
    end
  end

  assign ready_o   = ready_q;
  assign inhibit_o = inhibit_q;

  assert_ready_after_full_count_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> ($past(hcnt) == LAST) && $past(supply_ok));

  assert_supply_loss_locks_R6: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (inhibit_q && !ready_q && hcnt == '0));

endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard #(
  parameter int FILT_CYCLES = 2,
  parameter int HOLD_CYCLES = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic vdd_ok,
  output logic wr_start_o,
  output logic wr_inhibit_o
);

  import wg_pkg::*;

  localparam int          NSIG    = 4;
  localparam logic [NSIG-1:0] IDLE_VAL = 4'b1110;

  logic [NSIG-1:0] raw_bus;
  logic [NSIG-1:0] smp_bus;
  wg_ctrl_t        ctrl_s;
  logic            vdd_s;
  logic            req;
  logic            accept;
  logic            ready;
  logic            start_q;

  assign raw_bus = {ce_n, we_n, oe_n, vdd_ok};

  wg_sync #(
    .WIDTH   (NSIG),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IDLE_VAL)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_bus),
    .q   (smp_bus)
  );

  assign ctrl_s = wg_ctrl_t'(smp_bus[NSIG-1:1]);
  assign vdd_s  = smp_bus[0];
  assign req    = wg_is_write(ctrl_s);

  wg_strobe_filter #(
    .FILT_CYCLES (FILT_CYCLES)
  ) u_filter (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .accept (accept)
  );

  wg_holdoff #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_holdoff (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (vdd_s),
    .ready_o   (ready),
    .inhibit_o (wr_inhibit_o)
  );

  // The sampled supply flag gates directly, one cycle ahead of the timer state.
  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= accept && ready && vdd_s;
  end

  assign wr_start_o = start_q;

  assert_pulse_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    wr_start_o |=> !wr_start_o);

  assert_no_start_when_inhibited_R5: assert property (@(posedge clk) disable iff (rst)
    wr_start_o |-> !wr_inhibit_o);

  assert_start_needs_write_pins_R3: assert property (@(posedge clk) disable iff (rst)
    wr_start_o |-> $past(req) && $past(ctrl_s.oe_n) && !$past(ctrl_s.we_n));

  assert_low_supply_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    !vdd_s |=> !wr_start_o && wr_inhibit_o);

  assert_reset_state_R4: assert property (@(posedge clk)
    $past(rst) |-> !wr_start_o && wr_inhibit_o);

endmodule

// File: tb/test_nvm_write_guard.sv
`timescale 1ns/1ps
module test_nvm_write_guard;

  localparam int FILT = 5;
  localparam int HOLD = 40;
  localparam int SYNC = 2;
  localparam int WATCHDOG_CYC = 20000;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    int   len;
    int   exp;
  } vec_t;

  // Pin pattern, cycles held, pulses expected.
  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b0, 1'b1, FILT,     1},  // R1 exact minimum
    '{1'b0, 1'b0, 1'b1, FILT - 1, 0},  // R1 one short
    '{1'b0, 1'b0, 1'b1, 1,        0},  // R1 spike
    '{1'b0, 1'b0, 1'b1, 30,       1},  // R2 long hold, one pulse
    '{1'b0, 1'b0, 1'b0, 30,       0},  // R3 output enable low
    '{1'b1, 1'b0, 1'b1, 30,       0},  // R3 chip enable high
    '{1'b0, 1'b1, 1'b1, 30,       0},  // R3 write enable high
    '{1'b1, 1'b1, 1'b0, 30,       0},  // R3 read-idle pattern
    '{1'b0, 1'b0, 1'b1, FILT + 1, 1}   // R1 above minimum
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vdd_ok = 1'b0;
  logic wr_start, wr_inhibit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  nvm_write_guard #(
    .FILT_CYCLES (FILT),
    .HOLD_CYCLES (HOLD),
    .SYNC_STAGES (SYNC)
  ) i_nvm_write_guard (
    .clk          (clk),
    .rst          (rst),
    .ce_n         (ce_n),
    .we_n         (we_n),
    .oe_n         (oe_n),
    .vdd_ok       (vdd_ok),
    .wr_start_o   (wr_start),
    .wr_inhibit_o (wr_inhibit)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_pins();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  // Called right after a falling edge; holds the pattern for len edges.
  task automatic run_pattern(input logic c, input logic w, input logic o,
                             input int len, output int pulses);
    pulses = 0;
    ce_n = c; we_n = w; oe_n = o;
    repeat (len) begin
      @(negedge clk);
      pulses += int'(wr_start);
    end
    idle_pins();
    repeat (FILT + SYNC + 3) begin
      @(negedge clk);
      pulses += int'(wr_start);
    end
  endtask

  initial begin
    int p;
    repeat (3) @(negedge clk);
    chk("R4 start in reset", int'(wr_start), 0);
    chk("R4 inhibit in reset", int'(wr_inhibit), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 inhibit after reset", int'(wr_inhibit), 1);

    // R5 hold-off timing, with a request held across its end (R7).
    p = 0;
    vdd_ok = 1'b1;
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    for (int j = 1; j <= HOLD + SYNC + 10; j++) begin
      @(negedge clk);
      p += int'(wr_start);
      if (j == HOLD + SYNC - 1) chk("R5 inhibit before end", int'(wr_inhibit), 1);
      if (j == HOLD + SYNC)     chk("R5 inhibit released", int'(wr_inhibit), 0);
    end
    idle_pins();
    repeat (FILT + SYNC + 3) begin
      @(negedge clk);
      p += int'(wr_start);
    end
    chk("R7 request spent during hold-off", p, 0);

    // Table walk.
    foreach (VECS[k]) begin
      run_pattern(VECS[k].ce_n, VECS[k].we_n, VECS[k].oe_n, VECS[k].len, p);
      chk($sformatf("R1/R2/R3 vector %0d pulses", k), p, VECS[k].exp);
    end

    // R1 exact pulse timing, R2 width.
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    for (int j = 1; j <= FILT + SYNC + 2; j++) begin
      @(negedge clk);
      if (j == FILT + SYNC - 1) chk("R1 not yet started", int'(wr_start), 0);
      if (j == FILT + SYNC)     chk("R1 start cycle", int'(wr_start), 1);
      if (j == FILT + SYNC + 1) chk("R2 pulse is one cycle", int'(wr_start), 0);
    end
    idle_pins();
    repeat (FILT + SYNC + 3) @(negedge clk);

    // R3 chip-enable-last: write enable low first, chip enable later.
    p = 0;
    we_n = 1'b0;
    repeat (10) begin @(negedge clk); p += int'(wr_start); end
    ce_n = 1'b0;
    repeat (FILT - 1) begin @(negedge clk); p += int'(wr_start); end
    idle_pins();
    repeat (FILT + SYNC + 3) begin @(negedge clk); p += int'(wr_start); end
    chk("R3 short overlap after late chip enable", p, 0);
    run_pattern(1'b0, 1'b0, 1'b1, 3, p);
    chk("R3 three-cycle overlap rejected", p, 0);
    p = 0;
    we_n = 1'b0;
    repeat (10) begin @(negedge clk); p += int'(wr_start); end
    ce_n = 1'b0;
    repeat (FILT) begin @(negedge clk); p += int'(wr_start); end
    idle_pins();
    repeat (FILT + SYNC + 3) begin @(negedge clk); p += int'(wr_start); end
    chk("R3 late chip enable starts count", p, 1);

    // R8 one idle cycle between two full requests.
    p = 0;
    ce_n = 1'b0; we_n = 1'b0;
    repeat (FILT) begin @(negedge clk); p += int'(wr_start); end
    we_n = 1'b1;
    @(negedge clk); p += int'(wr_start);
    we_n = 1'b0;
    repeat (FILT) begin @(negedge clk); p += int'(wr_start); end
    idle_pins();
    repeat (FILT + SYNC + 3) begin @(negedge clk); p += int'(wr_start); end
    chk("R8 two requests two pulses", p, 2);

    // R6 supply lost in the middle of a request.
    p = 0;
    ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); p += int'(wr_start);
    @(negedge clk); p += int'(wr_start);
    vdd_ok = 1'b0;
    for (int j = 1; j <= FILT + SYNC + 5; j++) begin
      @(negedge clk);
      p += int'(wr_start);
      if (j == SYNC)     chk("R6 inhibit not yet", int'(wr_inhibit), 0);
      if (j == SYNC + 1) chk("R6 inhibit on supply loss", int'(wr_inhibit), 1);
    end
    idle_pins();
    repeat (FILT + SYNC + 3) begin @(negedge clk); p += int'(wr_start); end
    chk("R6 no pulse with supply low", p, 0);

    // R6 dip during hold-off restarts the full delay.
    vdd_ok = 1'b1;
    repeat (10) @(negedge clk);
    vdd_ok = 1'b0;
    @(negedge clk);
    vdd_ok = 1'b1;
    for (int j = 1; j <= HOLD + SYNC; j++) begin
      @(negedge clk);
      if (j == HOLD + SYNC - 1) chk("R6 restarted hold-off still on", int'(wr_inhibit), 1);
      if (j == HOLD + SYNC)     chk("R6 restarted hold-off ends", int'(wr_inhibit), 0);
    end
    run_pattern(1'b0, 1'b0, 1'b1, FILT, p);
    chk("R6 writes resume after recovery", p, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYC, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule